// File: doc/BRIEF.md
# Window Configuration Serial Slave

This block is a two-wire serial slave that lets a host read and write a small byte-wide register file holding the configuration of a write window and a read window. The two serial lines are oversampled by the system clock. The data line is open-drain: the block sees the resolved line level on one input, and it pulls the line low through one output. A low-active interface enable turns the whole interface on. While the enable is high, the block ignores the bus and never pulls the line.

A host writes a register with a transaction of three bytes: the write slave byte, the register index, and the data. A host reads a register in two steps. It first sets the index with the write slave byte, then issues a start (or a repeated start) with the read slave byte and clocks the register value out. Every configuration byte keeps only the bits that its field defines. The block presents the assembled multi-byte fields as parallel outputs to the rest of the chip.

Top module: `wincfg_serial_slave`

## Requirements
- R1: While `if_en_n` is high, `sda_pull_low` stays 0, no byte is acknowledged, and no register changes.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop returns the block to idle and drops any partial transaction. A start at any point begins a new slave byte.
- R3: Write transaction (start, 00h, index, data, stop): the slave pulls SDA low in the ninth clock of each of the three bytes, and the register at that index takes the data.
- R4: Read transaction (start, 00h, index, stop, start, 01h, then eight clocks): the slave acknowledges 00h, the index and 01h. It then drives the register value most significant bit first, with a 1 bit released and a 0 bit pulled low. It releases SDA during the host's not-acknowledge clock.
- R5: Index 00h reads 46h. A write to it is acknowledged and leaves it unchanged.
- R6: Unused upper bits read as zero. Kept bits per index: 03h, 07h and 0Ch keep [4:0]; 05h and 0Eh keep [1:0]; 0Ah keeps [7:5]; 10h keeps [3:0]; 13h keeps [7]. All other indexes 02h to 13h keep all eight bits.
- R7: A slave byte other than 00h or 01h is not acknowledged. The block then acknowledges nothing and writes nothing until the next start.
- R8: Indexes 01h and 14h to FFh are undefined. Writes to them are acknowledged and have no effect, and reads of them return 00h.
- R9: After reset every configuration register is 00h and `sda_pull_low` is 0.
- R10: The parallel outputs are formed as {high byte, low byte}. Write window: start = {03h[4:0], 02h}, width = {05h[1:0], 04h}, signed stride = {07h[4:0], 06h}, height = {09h, 08h}, and enable, x-mirror and freeze = 0Ah bits 7, 6 and 5. Read window: start = {0Ch[4:0], 0Bh}, width = {0Eh[1:0], 0Dh}, stride = {10h[3:0], 0Fh}, height = {12h, 11h}, and enable = 13h bit 7. The outputs change only when a register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Resolved level of the serial data line |
| if_en_n | input | 1 | Interface enable, low active |
| sda_pull_low | output | 1 | 1 pulls the serial data line low |
| wwin_start | output | 13 | Write window start block |
| wwin_xsize | output | 10 | Write window width |
| wwin_stride | output | 13 | Write window line stride, two's complement |
| wwin_ysize | output | 16 | Write window height |
| wwin_en | output | 1 | Write window mode on |
| wwin_xmirror | output | 1 | Write window horizontal mirror |
| wwin_freeze | output | 1 | Write window freeze |
| rwin_start | output | 13 | Read window start block |
| rwin_xsize | output | 10 | Read window width |
| rwin_stride | output | 12 | Read window line stride |
| rwin_ysize | output | 16 | Read window height |
| rwin_en | output | 1 | Read window mode on |

## Verification
The assertions assume that SCL and SDA never change in the same system clock. They also assume that the host changes SDA only while SCL is low, except to form a start or a stop. Each bus phase must last longer than the synchronizer latency, so that every edge is seen in order. The bench holds each phase for eight system clocks and moves SDA only in the middle of the low phase of SCL. On the read path it releases its own driver, so that the wired level shows only the slave's drive.

// File: rtl/wincfg_pkg.sv
package wincfg_pkg;

  localparam int BYTE_BITS  = 8;
  localparam int FIRST_CFG  = 2;
  localparam int LAST_CFG   = 19;
  localparam int NUM_CFG    = LAST_CFG - FIRST_CFG + 1;
  localparam int ID_INDEX   = 0;

  localparam int START_W    = 13;
  localparam int XSIZE_W    = 10;
  localparam int WSTRIDE_W  = 13;
  localparam int RSTRIDE_W  = 12;
  localparam int YSIZE_W    = 16;

  localparam logic [7:0] SLAVE_WR = 8'h00;
  localparam logic [7:0] SLAVE_RD = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_ADDR, S_INDEX, S_ACK_INDEX,
    S_WDATA, S_ACK_WDATA, S_RDATA, S_RACK, S_WAIT
  } ser_state_t;

  // Bits each configuration byte keeps; the others are held at zero.
  function automatic logic [7:0] cfg_keep(input int idx);
    case (idx)
      3, 7, 12: cfg_keep = 8'h1F;
      5, 14:    cfg_keep = 8'h03;
      10:       cfg_keep = 8'hE0;
      16:       cfg_keep = 8'h0F;
      19:       cfg_keep = 8'h80;
      default:  cfg_keep = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/ser_line_sampler.sv
module ser_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic en_n_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit,
  output logic disabled
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync, sda_sync, en_sync;
  logic         scl_q, sda_q;
  logic         scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      en_sync  <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[TOP-1:0], scl_i};
      sda_sync <= {sda_sync[TOP-1:0], sda_i};
      en_sync  <= {en_sync[TOP-1:0], en_n_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_sync[TOP];
  assign sda_s     = sda_sync[TOP];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_bit   = sda_s;
  assign disabled  = en_sync[TOP];

endmodule

// File: rtl/ser_protocol_fsm.sv
module ser_protocol_fsm
  import wincfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_bit,
  input  logic       disabled,
  input  logic [7:0] rd_data,
  output logic       sda_pull_low,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] reg_idx
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  ser_state_t       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [7:0]       shreg, shreg_n, idx_n, wd_n;
  logic             rnw, rnw_n, oe_n, we_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    shreg_n = shreg;
    idx_n   = reg_idx;
    rnw_n   = rnw;
    oe_n    = sda_pull_low;
    we_n    = 1'b0;
    wd_n    = wr_data;
    if (disabled) begin
      state_n = S_IDLE;
      oe_n    = 1'b0;
      cnt_n   = '0;
    end else if (stop_det) begin
      state_n = S_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = S_ADDR;
      oe_n    = 1'b0;
      cnt_n   = '0;
    end else begin
      case (state)
        S_ADDR, S_INDEX, S_WDATA: begin
          if (scl_rise) begin
            shreg_n = {shreg[6:0], sda_bit};
            cnt_n   = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            cnt_n = '0;
            if (state == S_ADDR) begin
              if (shreg == SLAVE_WR || shreg == SLAVE_RD) begin
                rnw_n   = shreg[0];
                oe_n    = 1'b1;
                state_n = S_ACK_ADDR;
              end else begin
                state_n = S_WAIT;
              end
            end else if (state == S_INDEX) begin
              idx_n   = shreg;
              oe_n    = 1'b1;
              state_n = S_ACK_INDEX;
            end else begin
              we_n    = 1'b1;
              wd_n    = shreg;
              oe_n    = 1'b1;
              state_n = S_ACK_WDATA;
            end
          end
        end
        S_ACK_ADDR: if (scl_fall) begin
          cnt_n = '0;
          if (rnw) begin
            shreg_n = rd_data;
            oe_n    = ~rd_data[7];
            state_n = S_RDATA;
          end else begin
            oe_n    = 1'b0;
            state_n = S_INDEX;
          end
        end
        S_ACK_INDEX: if (scl_fall) begin
          cnt_n   = '0;
          oe_n    = 1'b0;
          state_n = S_WDATA;
        end
        S_ACK_WDATA: if (scl_fall) begin
          oe_n    = 1'b0;
          state_n = S_WAIT;
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              oe_n    = 1'b0;
              state_n = S_RACK;
            end else begin
              shreg_n = {shreg[6:0], 1'b0};
              oe_n    = ~shreg[6];
            end
          end
        end
        S_RACK: if (scl_fall) state_n = S_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      reg_idx      <= '0;
      rnw          <= 1'b0;
      sda_pull_low <= 1'b0;
      wr_en        <= 1'b0;
      wr_data      <= '0;
    end else begin
      state        <= state_n;
      cnt          <= cnt_n;
      shreg        <= shreg_n;
      reg_idx      <= idx_n;
      rnw          <= rnw_n;
      sda_pull_low <= oe_n;
      wr_en        <= we_n;
      wr_data      <= wd_n;
    end
  end

  // R1: a disabled interface lets go of the line
  a_r1_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> !sda_pull_low);
  // R2: a stop ends any transaction
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !disabled) |=> (state == S_IDLE && !sda_pull_low));
  // R4: the line is pulled only in acknowledge or read-data phases
  a_r4_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> (state inside {S_ACK_ADDR, S_ACK_INDEX, S_ACK_WDATA, S_RDATA}));
  // R7: after a refused slave byte the line stays released
  a_r7_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> !sda_pull_low);
  // R3: one register write per data byte
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/wincfg_regfile.sv
module wincfg_regfile
  import wincfg_pkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'h46
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           rd_idx,
  output logic [7:0]           rd_data,
  output logic [NUM_CFG*8-1:0] cfg_flat
);

  for (genvar i = FIRST_CFG; i <= LAST_CFG; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (wr_en && wr_idx == 8'(i)) q <= wr_data & cfg_keep(i);
    end
    assign cfg_flat[(i-FIRST_CFG)*8 +: 8] = q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == 8'(ID_INDEX)) rd_data = ID_CODE;
    for (int i = FIRST_CFG; i <= LAST_CFG; i++)
      if (rd_idx == 8'(i)) rd_data = cfg_flat[(i-FIRST_CFG)*8 +: 8];
  end

endmodule

// File: rtl/wincfg_serial_slave.sv
module wincfg_serial_slave
  import wincfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_CODE     = 8'h46
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 if_en_n,
  output logic                 sda_pull_low,
  output logic [START_W-1:0]   wwin_start,
  output logic [XSIZE_W-1:0]   wwin_xsize,
  output logic [WSTRIDE_W-1:0] wwin_stride,
  output logic [YSIZE_W-1:0]   wwin_ysize,
  output logic                 wwin_en,
  output logic                 wwin_xmirror,
  output logic                 wwin_freeze,
  output logic [START_W-1:0]   rwin_start,
  output logic [XSIZE_W-1:0]   rwin_xsize,
  output logic [RSTRIDE_W-1:0] rwin_stride,
  output logic [YSIZE_W-1:0]   rwin_ysize,
  output logic                 rwin_en
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic scl_rise, scl_fall, start_det, stop_det, sda_bit, disabled;
  logic wr_en;
  logic [7:0] wr_data, reg_idx, rd_data;
  logic [NUM_CFG*8-1:0] cfg_flat;
  logic [7:0] rb [FIRST_CFG:LAST_CFG];

  ser_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .en_n_i(if_en_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .disabled(disabled));

  ser_protocol_fsm fsm_i (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .disabled(disabled), .rd_data(rd_data), .sda_pull_low(sda_pull_low),
    .wr_en(wr_en), .wr_data(wr_data), .reg_idx(reg_idx));

  wincfg_regfile #(.ID_CODE(ID_CODE)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(reg_idx),
    .wr_data(wr_data), .rd_idx(reg_idx), .rd_data(rd_data),
    .cfg_flat(cfg_flat));

  for (genvar i = FIRST_CFG; i <= LAST_CFG; i++) begin : g_slice
    assign rb[i] = cfg_flat[(i-FIRST_CFG)*8 +: 8];
  end

  assign wwin_start   = {rb[3][4:0], rb[2]};
  assign wwin_xsize   = {rb[5][1:0], rb[4]};
  assign wwin_stride  = {rb[7][4:0], rb[6]};
  assign wwin_ysize   = {rb[9], rb[8]};
  assign wwin_en      = rb[10][7];
  assign wwin_xmirror = rb[10][6];
  assign wwin_freeze  = rb[10][5];
  assign rwin_start   = {rb[12][4:0], rb[11]};
  assign rwin_xsize   = {rb[14][1:0], rb[13]};
  assign rwin_stride  = {rb[16][3:0], rb[15]};
  assign rwin_ysize   = {rb[18], rb[17]};
  assign rwin_en      = rb[19][7];

  // R10: the parallel fields move only on a register write
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable({wwin_start, wwin_xsize, wwin_stride, wwin_ysize, wwin_en,
                        wwin_xmirror, wwin_freeze, rwin_start, rwin_xsize,
                        rwin_stride, rwin_ysize, rwin_en}));

endmodule

// File: tb/wincfg_serial_slave_tb_top.sv
`timescale 1ns/1ps
module wincfg_serial_slave_tb_top;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_host = 1'b1, if_en_n = 1'b0;
  logic sda_pull_low, sda_line;
  logic [12:0] wwin_start, rwin_start, wwin_stride;
  logic [9:0]  wwin_xsize, rwin_xsize;
  logic [15:0] wwin_ysize, rwin_ysize;
  logic [11:0] rwin_stride;
  logic wwin_en, wwin_xmirror, wwin_freeze, rwin_en;

  int n_chk = 0, n_bad = 0, oe_off_hits = 0;
  bit watch_off = 0, done = 0;
  logic [7:0] mdl [0:255];

  assign sda_line = sda_host & ~sda_pull_low;

  always #10 clk = ~clk;

  wincfg_serial_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .if_en_n(if_en_n),
    .sda_pull_low(sda_pull_low), .wwin_start(wwin_start), .wwin_xsize(wwin_xsize),
    .wwin_stride(wwin_stride), .wwin_ysize(wwin_ysize), .wwin_en(wwin_en),
    .wwin_xmirror(wwin_xmirror), .wwin_freeze(wwin_freeze), .rwin_start(rwin_start),
    .rwin_xsize(rwin_xsize), .rwin_stride(rwin_stride), .rwin_ysize(rwin_ysize),
    .rwin_en(rwin_en));

  always @(negedge clk) if (watch_off && sda_pull_low) oe_off_hits++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  function automatic logic [7:0] keep_of(int idx);
    case (idx)
      3, 7, 12: return 8'h1F;
      5, 14:    return 8'h03;
      10:       return 8'hE0;
      16:       return 8'h0F;
      19:       return 8'h80;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(int idx);
    if (idx == 0) return 8'h46;
    if (idx >= 2 && idx <= 19) return mdl[idx];
    return 8'h00;
  endfunction

  task automatic bus_start;
    sda_host = 1'b1; tick(HP); scl = 1'b1; tick(HP);
    sda_host = 1'b0; tick(HP); scl = 1'b0; tick(HP);
  endtask

  task automatic bus_stop;
    sda_host = 1'b0; tick(HP); scl = 1'b1; tick(HP); sda_host = 1'b1; tick(HP);
  endtask

  task automatic bus_bit(input bit b, output bit seen);
    sda_host = b; tick(HP); scl = 1'b1; tick(HP/2);
    seen = sda_line; tick(HP/2); scl = 1'b0; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit nak);
    bit d;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], d);
    bus_bit(1'b1, nak);
  endtask

  task automatic recv_byte(output logic [7:0] v, output bit rel);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      bus_bit(1'b1, b);
      v[i] = b;
    end
    bus_bit(1'b1, rel);
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, output logic [2:0] naks);
    bit a0, a1, a2;
    bus_start; send_byte(8'h00, a0); send_byte(idx, a1); send_byte(d, a2); bus_stop;
    naks = {a0, a1, a2};
    if (!if_en_n && idx >= 2 && idx <= 19) mdl[idx] = d & keep_of(idx);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] v, output logic [2:0] naks, output bit rel);
    bit a0, a1, a2;
    bus_start; send_byte(8'h00, a0); send_byte(idx, a1); bus_stop;
    bus_start; send_byte(8'h01, a2); recv_byte(v, rel); bus_stop;
    naks = {a0, a1, a2};
  endtask

  task automatic check_fields(string tag);
    chk({tag, " R10 wwin_start"},  32'(wwin_start),  32'({mdl[3][4:0], mdl[2]}));
    chk({tag, " R10 wwin_xsize"},  32'(wwin_xsize),  32'({mdl[5][1:0], mdl[4]}));
    chk({tag, " R10 wwin_stride"}, 32'(wwin_stride), 32'({mdl[7][4:0], mdl[6]}));
    chk({tag, " R10 wwin_ysize"},  32'(wwin_ysize),  32'({mdl[9], mdl[8]}));
    chk({tag, " R10 wwin_ctrl"},   32'({wwin_en, wwin_xmirror, wwin_freeze}), 32'(mdl[10][7:5]));
    chk({tag, " R10 rwin_start"},  32'(rwin_start),  32'({mdl[12][4:0], mdl[11]}));
    chk({tag, " R10 rwin_xsize"},  32'(rwin_xsize),  32'({mdl[14][1:0], mdl[13]}));
    chk({tag, " R10 rwin_stride"}, 32'(rwin_stride), 32'({mdl[16][3:0], mdl[15]}));
    chk({tag, " R10 rwin_ysize"},  32'(rwin_ysize),  32'({mdl[18], mdl[17]}));
    chk({tag, " R10 rwin_en"},     32'(rwin_en),     32'(mdl[19][7]));
  endtask

  task automatic t_reset;
    chk("R9 sda_pull_low after reset", 32'(sda_pull_low), 0);
    check_fields("R9 reset");
  endtask

  task automatic t_write_read;
    logic [2:0] n; logic [7:0] v; bit rel;
    reg_write(8'h02, 8'hA5, n); chk("R3 acks on write", 32'(n), 0);
    reg_write(8'h03, 8'hFF, n); chk("R3 acks on write hi", 32'(n), 0);
    chk("R10 wwin_start", 32'(wwin_start), 32'h1FA5);
    reg_read(8'h02, v, n, rel);
    chk("R4 acks on read", 32'(n), 0);
    chk("R4 read data 02h", 32'(v), 32'hA5);
    chk("R4 released in nack clock", 32'(rel), 1);
    reg_read(8'h03, v, n, rel); chk("R6 read 03h masked", 32'(v), 32'h1F);
  endtask

  task automatic t_masks;
    logic [2:0] n; logic [7:0] v; bit rel;
    int hi [7] = '{5, 7, 10, 12, 14, 16, 19};
    foreach (hi[k]) begin
      reg_write(8'(hi[k]), 8'hFF, n);
      reg_read(8'(hi[k]), v, n, rel);
      chk($sformatf("R6 keep bits of %0h", hi[k]), 32'(v), 32'(keep_of(hi[k])));
    end
    reg_write(8'h06, 8'h00, n); reg_write(8'h07, 8'h10, n);
    reg_write(8'h08, 8'h34, n); reg_write(8'h09, 8'h12, n);
    reg_write(8'h0F, 8'h9C, n); reg_write(8'h11, 8'hEF, n); reg_write(8'h12, 8'hBE, n);
    reg_write(8'h0A, 8'h40, n); reg_write(8'h0B, 8'h77, n); reg_write(8'h04, 8'h3C, n);
    check_fields("fields");
  endtask

  task automatic t_id;
    logic [2:0] n; logic [7:0] v; bit rel;
    reg_read(8'h00, v, n, rel); chk("R5 id read", 32'(v), 32'h46);
    reg_write(8'h00, 8'h12, n); chk("R5 id write acked", 32'(n), 0);
    reg_read(8'h00, v, n, rel); chk("R5 id unchanged", 32'(v), 32'h46);
  endtask

  task automatic t_undef;
    logic [2:0] n; logic [7:0] v; bit rel;
    reg_write(8'h01, 8'h55, n); chk("R8 write 01h acked", 32'(n), 0);
    reg_write(8'h14, 8'h77, n); chk("R8 write 14h acked", 32'(n), 0);
    reg_read(8'h01, v, n, rel); chk("R8 read 01h", 32'(v), 0);
    reg_read(8'h14, v, n, rel); chk("R8 read 14h", 32'(v), 0);
    reg_read(8'hFF, v, n, rel); chk("R8 read FFh", 32'(v), 0);
    check_fields("R8 after undefined writes");
  endtask

  task automatic t_bad_slave;
    bit a0, a1, a2; logic [7:0] v; logic [2:0] n; bit rel;
    bus_start; send_byte(8'hA0, a0); send_byte(8'h02, a1); send_byte(8'h33, a2); bus_stop;
    chk("R7 slave A0h refused", 32'(a0), 1);
    chk("R7 later bytes refused", 32'({a1, a2}), 32'b11);
    bus_start; send_byte(8'h02, a0); send_byte(8'h00, a1); bus_stop;
    chk("R7 slave 02h refused", 32'({a0, a1}), 32'b11);
    reg_read(8'h02, v, n, rel); chk("R7 register kept", 32'(v), 32'(mdl[2]));
  endtask

  task automatic t_disabled;
    logic [2:0] n; logic [7:0] v; bit rel;
    if_en_n = 1'b1; tick(10); watch_off = 1;
    reg_write(8'h02, 8'h99, n);
    chk("R1 no ack while disabled", 32'(n), 32'b111);
    watch_off = 0;
    chk("R1 line never pulled", 32'(oe_off_hits), 0);
    if_en_n = 1'b0; tick(10);
    reg_read(8'h02, v, n, rel); chk("R1 register unchanged", 32'(v), 32'(mdl[2]));
  endtask

  task automatic t_framing;
    bit a0, a1, a2, d; logic [7:0] v; logic [2:0] n; bit rel;
    bus_start; send_byte(8'h00, a0); send_byte(8'h0D, a1); bus_stop;
    chk("R2 index-only write leaves rwin_xsize", 32'(rwin_xsize), 32'({mdl[14][1:0], mdl[13]}));
    bus_start; for (int i = 0; i < 4; i++) bus_bit(1'b1, d); bus_stop;
    reg_write(8'h0D, 8'h5A, n); chk("R2 write after aborted byte", 32'(n), 0);
    chk("R2 rwin_xsize low byte", 32'(rwin_xsize[7:0]), 32'h5A);
    bus_start; send_byte(8'h00, a0); send_byte(8'h11, a1);
    bus_start; send_byte(8'h00, a0); send_byte(8'h18, a1); send_byte(8'h0C, a2); bus_stop;
    chk("R2 repeated start acks", 32'({a0, a1, a2}), 0);
    bus_start; send_byte(8'h00, a0); send_byte(8'h08, a1);
    bus_start; send_byte(8'h01, a2); recv_byte(v, rel); bus_stop;
    chk("R2 read via repeated start", 32'(v), 32'(mdl[8]));
    reg_read(8'h11, v, n, rel); chk("R2 first index not written", 32'(v), 32'(mdl[17]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(10);
    t_reset;
    t_write_read;
    t_masks;
    t_id;
    t_undef;
    t_bad_slave;
    t_disabled;
    t_framing;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule